// File: doc/BRIEF.md
# Grouped Pulse-Rate Generator with Frequency Ramp

This block sets the pulse rate for a group of four PWM channels. A small write port loads two settings: a target frequency in pulses per second, and a ramp duration counted in 10 ms ticks. The block turns the frequency in effect into a period length in system clock cycles. It also emits a one-cycle strobe at the start of every period. The four channels of the group use both outputs. A chip with twelve channels uses three instances.

When the ramp duration is zero, a new target takes effect at once. Otherwise the frequency moves toward the target in linear steps, one step per tick, and the last step lands exactly on the target. The ramp duration is captured when a ramp starts. Changing it while a ramp is running therefore only affects later ramps. A new target written during a ramp starts a fresh ramp from the frequency in effect at that moment.

Top module: `grp_freq_ramp`

## Requirements
- R1: After reset, `freq_now`, `period_len`, `period_strobe` and `ramp_busy` are all 0, and the stored target and ramp duration are 0.
- R2: A frequency write (`wr_sel`=0) larger than 4000 is saturated to 4000, and `freq_now` never exceeds 4000.
- R3: When the stored ramp duration is 0, a frequency write sets `freq_now` to the new value on the clock edge that takes the write, and `period_len` follows one edge later.
- R4: For a nonzero frequency f, `period_len` equals CLK_HZ / f (integer division). Consecutive strobes are exactly `period_len` cycles apart.
- R5: With frequency 0, `period_len` is 0 and `period_strobe` stays low.
- R6: When the ramp duration N is nonzero, a frequency write starts a ramp, and the tick prescaler restarts at that write. Every TICK_CYCLES cycles, `freq_now` moves toward the target by |target − freq_now| / remaining ticks, rounded down. After the Nth step it equals the target.
- R7: A ramp-duration write (`wr_sel`=1) during a ramp leaves the length and steps of that ramp unchanged, and it applies to the next ramp.
- R8: A frequency write during a ramp restarts the ramp from the current `freq_now`, toward the new target, using the stored ramp duration.
- R9: `ramp_busy` is high from the edge that starts a ramp until the edge of its final step. With `ramp_busy` low and no frequency write, `freq_now` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for one setting |
| wr_sel | input | 1 | 0 = target frequency, 1 = ramp duration in ticks |
| wr_data | input | DATA_W (16) | Value written |
| freq_now | output | FREQ_W (12) | Frequency in effect, pulses per second |
| period_len | output | PER_W (28) | Period length in clock cycles, 0 when stopped |
| period_strobe | output | 1 | One-cycle pulse at the start of each period |
| ramp_busy | output | 1 | A ramp is in progress |

## Verification
A write is taken on one rising edge. Direct updates show on `freq_now` half a cycle later, at the next falling edge. `period_len` shows one falling edge after that, because it is registered from `freq_now`. Ramp step k shows k·TICK_CYCLES cycles after the starting edge. The bench therefore samples at the falling edge just before and just after each step, and it subtracts the cycles used by any write issued during a ramp. Strobe spacing is measured by counting falling edges between two strobes, taken after the first strobe that follows a change.

// File: rtl/grpf_pkg.sv
package grpf_pkg;
  localparam logic SEL_FREQ = 1'b0;
  localparam logic SEL_RAMP = 1'b1;
endpackage

// File: rtl/grpf_tick.sv
// Prescaler producing the ramp step tick; restarts when a ramp begins.
module grpf_tick #(
  parameter int unsigned TICK_CYCLES = 2_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick = (cnt_q == LAST);
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/grpf_ramp.sv
// Holds settings and moves the frequency in effect toward the target.
module grpf_ramp
  import grpf_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned FREQ_W   = 12,
  parameter int unsigned FREQ_MAX = 4000,
  parameter int unsigned RAMP_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  output logic              start,
  output logic [FREQ_W-1:0] cur,
  output logic [FREQ_W-1:0] target,
  output logic [RAMP_W-1:0] ramp_cfg,
  output logic              busy
);
  localparam int unsigned QW = FREQ_W + RAMP_W;

  logic [RAMP_W-1:0] cfg_q, cfg_d, left_q, left_d;
  logic [FREQ_W-1:0] tgt_q, tgt_d, cur_q, cur_d, clamped, mag, step;
  logic [QW-1:0]     quo;
  logic              busy_q, busy_d, up, wr_freq, wr_ramp;
  logic              cfg_en, tgt_en, run_en;

  always_comb begin
    wr_freq = wr_en && (wr_sel == SEL_FREQ);
    wr_ramp = wr_en && (wr_sel == SEL_RAMP);
    clamped = (wr_data > DATA_W'(FREQ_MAX)) ? FREQ_W'(FREQ_MAX) : FREQ_W'(wr_data);
    up      = (tgt_q >= cur_q);
    mag     = up ? (tgt_q - cur_q) : (cur_q - tgt_q);
    quo     = (left_q == '0) ? QW'(mag) : (QW'(mag) / QW'(left_q));
    step    = FREQ_W'(quo);
    start   = wr_freq && (cfg_q != '0);

    cfg_en  = wr_ramp;
    cfg_d   = RAMP_W'(wr_data);
    tgt_en  = wr_freq;
    tgt_d   = clamped;

    run_en  = wr_freq || (busy_q && tick);
    cur_d   = cur_q;
    left_d  = left_q;
    busy_d  = busy_q;
    if (wr_freq) begin
      if (cfg_q == '0) begin
        cur_d  = clamped;
        left_d = '0;
        busy_d = 1'b0;
      end else begin
        left_d = cfg_q;
        busy_d = 1'b1;
      end
    end else if (busy_q && tick) begin
      cur_d  = up ? (cur_q + step) : (cur_q - step);
      left_d = left_q - 1'b1;
      busy_d = (left_q != RAMP_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      tgt_q  <= '0;
      cur_q  <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
    end else begin
      if (cfg_en) cfg_q <= cfg_d;
      if (tgt_en) tgt_q <= tgt_d;
      if (run_en) begin
        cur_q  <= cur_d;
        left_q <= left_d;
        busy_q <= busy_d;
      end
    end
  end

  assign cur      = cur_q;
  assign target   = tgt_q;
  assign ramp_cfg = cfg_q;
  assign busy     = busy_q;
endmodule

// File: rtl/grpf_period.sv
// Converts frequency to period length and times the period strobe.
module grpf_period #(
  parameter int unsigned CLK_HZ = 200_000_000,
  parameter int unsigned FREQ_W = 12,
  parameter int unsigned PER_W  = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREQ_W-1:0] freq,
  output logic [PER_W-1:0]  len,
  output logic              strobe
);
  logic [PER_W-1:0] len_q, len_d, cnt_q, cnt_d;
  logic             stb_q, stb_d;

  always_comb begin
    len_d = (freq == '0) ? '0 : PER_W'(CLK_HZ / 32'(freq));
    stb_d = (len_q != '0) && (cnt_q == '0);
    if (len_q == '0)      cnt_d = '0;
    else if (cnt_q == '0) cnt_d = len_q - 1'b1;
    else                  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      len_q <= len_d;
      cnt_q <= cnt_d;
      stb_q <= stb_d;
    end
  end

  assign len    = len_q;
  assign strobe = stb_q;
endmodule

// File: rtl/grp_freq_ramp.sv
module grp_freq_ramp #(
  parameter  int unsigned CLK_HZ      = 200_000_000,
  parameter  int unsigned TICK_CYCLES = 2_000_000,
  parameter  int unsigned DATA_W      = 16,
  parameter  int unsigned FREQ_W      = 12,
  parameter  int unsigned FREQ_MAX    = 4000,
  parameter  int unsigned RAMP_W      = 16,
  localparam int unsigned PER_W       = $clog2(CLK_HZ + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [FREQ_W-1:0] freq_now,
  output logic [PER_W-1:0]  period_len,
  output logic              period_strobe,
  output logic              ramp_busy
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n, tick, start;
  logic [FREQ_W-1:0] target_w;
  logic [RAMP_W-1:0] ramp_cfg_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  grpf_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_int_n), .restart(start), .tick(tick)
  );

  grpf_ramp #(
    .DATA_W(DATA_W), .FREQ_W(FREQ_W), .FREQ_MAX(FREQ_MAX), .RAMP_W(RAMP_W)
  ) u_ramp (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .tick(tick), .start(start), .cur(freq_now),
    .target(target_w), .ramp_cfg(ramp_cfg_w), .busy(ramp_busy)
  );

  grpf_period #(.CLK_HZ(CLK_HZ), .FREQ_W(FREQ_W), .PER_W(PER_W)) u_period (
    .clk(clk), .rst_n(rst_int_n), .freq(freq_now),
    .len(period_len), .strobe(period_strobe)
  );
endmodule

// File: rtl/grpf_chk.sv
module grpf_chk #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned FREQ_W   = 12,
  parameter int unsigned FREQ_MAX = 4000,
  parameter int unsigned RAMP_W   = 16,
  parameter int unsigned PER_W    = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic [FREQ_W-1:0] freq_now,
  input logic [PER_W-1:0]  period_len,
  input logic              period_strobe,
  input logic              ramp_busy,
  input logic [FREQ_W-1:0] target,
  input logic [RAMP_W-1:0] ramp_cfg
);
  a_r2_freq_capped: assert property (@(posedge clk) disable iff (!rst_n)
    32'(freq_now) <= FREQ_MAX);

  a_r3_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && ramp_cfg == '0) |=>
      (32'(freq_now) == ((32'($past(wr_data)) > FREQ_MAX) ? FREQ_MAX : 32'($past(wr_data)))));

  a_r5_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (period_len == '0 && $past(period_len) == '0) |-> !period_strobe);

  a_r6_lands_on_target: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ramp_busy) |-> (freq_now == target));

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!ramp_busy && !(wr_en && !wr_sel)) |=> $stable(freq_now));
endmodule

bind grp_freq_ramp grpf_chk #(
  .DATA_W(DATA_W), .FREQ_W(FREQ_W), .FREQ_MAX(FREQ_MAX),
  .RAMP_W(RAMP_W), .PER_W(PER_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .freq_now(freq_now), .period_len(period_len), .period_strobe(period_strobe),
  .ramp_busy(ramp_busy), .target(target_w), .ramp_cfg(ramp_cfg_w)
);

// File: tb/grp_freq_ramp_tb.sv
module grp_freq_ramp_tb;
  localparam int unsigned CLK_HZ = 400_000;
  localparam int unsigned T      = 200;
  localparam int unsigned PER_W  = $clog2(CLK_HZ + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic             wr_sel = 1'b0;
  logic [15:0]      wr_data = '0;
  logic [11:0]      freq_now;
  logic [PER_W-1:0] period_len;
  logic             period_strobe;
  logic             ramp_busy;

  int ntest = 0;
  int nfail = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  grp_freq_ramp #(.CLK_HZ(CLK_HZ), .TICK_CYCLES(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .freq_now(freq_now), .period_len(period_len),
    .period_strobe(period_strobe), .ramp_busy(ramp_busy)
  );

  task automatic check(input string req, input int act, input int exp);
    ntest++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input int val);
    wr_en = 1'b1; wr_sel = sel; wr_data = 16'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic gap(output int g);
    g = 0;
    for (int i = 0; i < 5000 && !period_strobe; i++) @(negedge clk);
    do begin @(negedge clk); g++; end while (!period_strobe && g < 5000);
  endtask

  task automatic t_reset;
    check("R1 freq_now", int'(freq_now), 0);
    check("R1 period_len", int'(period_len), 0);
    check("R1 strobe", int'(period_strobe), 0);
    check("R1 busy", int'(ramp_busy), 0);
  endtask

  task automatic t_direct;
    int g;
    wr(1'b0, 1000);
    check("R3 freq immediate", int'(freq_now), 1000);
    @(negedge clk);
    check("R3 period_len follows", int'(period_len), 400);
    gap(g);
    check("R4 spacing 1000", g, 400);
    wr(1'b0, 5000);
    check("R2 saturated", int'(freq_now), 4000);
    @(negedge clk);
    check("R4 len at 4000", int'(period_len), 100);
    gap(g);
    check("R4 spacing 4000", g, 100);
  endtask

  task automatic t_zero;
    int cnt = 0;
    wr(1'b0, 0);
    repeat (3) @(negedge clk);
    check("R5 len zero", int'(period_len), 0);
    for (int i = 0; i < 1000; i++) begin
      if (period_strobe) cnt++;
      @(negedge clk);
    end
    check("R5 no strobes", cnt, 0);
  endtask

  task automatic t_ramp_up;
    wr(1'b1, 4);
    wr(1'b0, 1000);
    check("R9 busy at start", int'(ramp_busy), 1);
    repeat (T - 1) @(negedge clk);
    check("R6 before first step", int'(freq_now), 0);
    @(negedge clk);
    check("R6 step1", int'(freq_now), 250);
    repeat (T) @(negedge clk);
    check("R6 step2", int'(freq_now), 500);
    repeat (T) @(negedge clk);
    check("R6 step3", int'(freq_now), 750);
    check("R9 busy before last", int'(ramp_busy), 1);
    repeat (T) @(negedge clk);
    check("R6 final on target", int'(freq_now), 1000);
    check("R9 busy cleared", int'(ramp_busy), 0);
    repeat (T) @(negedge clk);
    check("R9 held idle", int'(freq_now), 1000);
  endtask

  task automatic t_ramp_latch;
    int g;
    wr(1'b1, 3);
    wr(1'b0, 0);
    repeat (T) @(negedge clk);
    check("R6 down step1", int'(freq_now), 667);
    wr(1'b1, 1);
    repeat (T - 1) @(negedge clk);
    check("R7 step2 unchanged", int'(freq_now), 334);
    check("R7 still busy", int'(ramp_busy), 1);
    repeat (T) @(negedge clk);
    check("R7 step3 lands", int'(freq_now), 0);
    check("R7 busy after 3", int'(ramp_busy), 0);
    wr(1'b0, 400);
    repeat (T - 1) @(negedge clk);
    check("R7 next ramp pending", int'(freq_now), 0);
    @(negedge clk);
    check("R7 next ramp one tick", int'(freq_now), 400);
    check("R7 next ramp done", int'(ramp_busy), 0);
    @(negedge clk);
    check("R4 len at 400", int'(period_len), 1000);
    gap(g);
    check("R4 spacing 400", g, 1000);
  endtask

  task automatic t_retarget;
    wr(1'b1, 2);
    wr(1'b0, 1200);
    repeat (T) @(negedge clk);
    check("R8 first step", int'(freq_now), 800);
    wr(1'b0, 0);
    check("R8 restart holds value", int'(freq_now), 800);
    check("R8 busy restart", int'(ramp_busy), 1);
    repeat (T) @(negedge clk);
    check("R8 new step1", int'(freq_now), 400);
    repeat (T) @(negedge clk);
    check("R8 new final", int'(freq_now), 0);
    check("R8 busy end", int'(ramp_busy), 0);
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", ntest + 1, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_direct;
    t_zero;
    t_ramp_up;
    t_ramp_latch;
    t_retarget;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
    end
  end
endmodule